// File: doc/BRIEF.md
# Error Capture Register Bank

This block keeps a snapshot of the header fields that belong to a logical/transport-layer error in a packet interface. Two 32-bit capture words are held: one for the destination and source device IDs, and one for the packet format type, the transaction type and eight bits of message information. User logic drives each field through its own value input and write strobe. It raises those strobes in the same clock cycle as the error-detect pulse, so the stored fields describe that error.

The first detected error sets an error flag, and the flag freezes both capture words. Later strobes and host writes to those words have no effect until software clears the flag through the host register port. That port is a simple select/write/address bus with a combinational read path. Software can read all three registers, overwrite an unlocked capture word, and set or clear the flag.

The upper message-info nibble has two writers. A segment writer and an extended-mailbox writer share it, and the segment writer has the higher priority. The lower nibble is split between a letter writer and a mailbox writer. These two touch separate bits, so both can write in the same cycle.

Top module: `errcap_bank`

## Requirements
- R1: After a synchronous active-low reset, every capture field and the error flag are zero, so offsets 0x304, 0x308 and 0x30C all read 0.
- R2: When a strobe is 1 at a rising clock edge and the bank is unlocked, its value input is stored in its field. The ID word at offset 0x30C holds the destination ID in bits [31:16] and the source ID in bits [15:0]. A field whose strobe is low keeps its value.
- R3: In the control word at offset 0x308, the format type sits in bits [31:28] and the transaction type in bits [27:24]. Each has its own strobe and value pair.
- R4: Message info occupies control bits [23:16]. The 2-bit letter goes to message-info bits [1:0] and the 2-bit mailbox to bits [3:2]. Both may be stored in the same cycle.
- R5: When the segment strobe is 1, the 4-bit segment value is stored in message-info bits [7:4], whatever the extended-mailbox strobe is.
- R6: The 4-bit extended-mailbox value is stored in message-info bits [7:4] only when its strobe is 1 and the segment strobe is 0.
- R7: An error-detect pulse sets the error flag (bit 0 at offset 0x304) at that clock edge. From the next edge on, all field strobes are ignored while the flag is set.
- R8: A host write to offset 0x304 loads write-data bit 0 into the flag, so writing 0 clears it and unlocks the bank. An error-detect pulse in the same cycle wins and leaves the flag set.
- R9: A host write to 0x308 or 0x30C while unlocked replaces the whole capture word. Field strobes in the same cycle take priority for their own fields. Bits with no field (control bits [15:0], flag-register bits [31:1]) always read zero.
- R10: Host writes to 0x308 or 0x30C while the flag is set leave the capture words unchanged.
- R11: Reads of any offset other than 0x304, 0x308 and 0x30C, and any read with the select low, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| err_det_i | input | 1 | Error-detect pulse from user logic |
| dst_wr_i | input | 1 | Destination ID strobe |
| dst_val_i | input | 16 | Destination ID value |
| src_wr_i | input | 1 | Source ID strobe |
| src_val_i | input | 16 | Source ID value |
| fmt_wr_i | input | 1 | Format-type strobe |
| fmt_val_i | input | 4 | Format-type value |
| txn_wr_i | input | 1 | Transaction-type strobe |
| txn_val_i | input | 4 | Transaction-type value |
| ltr_wr_i | input | 1 | Letter strobe |
| ltr_val_i | input | 2 | Letter value |
| mbx_wr_i | input | 1 | Mailbox strobe |
| mbx_val_i | input | 2 | Mailbox value |
| seg_wr_i | input | 1 | Segment strobe (high priority on upper nibble) |
| seg_val_i | input | 4 | Segment value |
| xmbx_wr_i | input | 1 | Extended-mailbox strobe (low priority on upper nibble) |
| xmbx_val_i | input | 4 | Extended-mailbox value |
| host_sel_i | input | 1 | Host access select |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 12 | Host byte offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |

## Verification
Every stored result appears at the rising edge where its strobe, error pulse or host write is sampled. The host read path adds no register, so a value is visible one edge after its stimulus. The bench drives stimulus on the falling edge and lets one rising edge pass. It then reads on the following falling edge, so each check lands exactly one cycle after the stimulus. Lock checks go one edge further: they apply fresh strobes after the flag has been set and expect the words to be unchanged on the next read.

// File: rtl/errcap_pkg.sv
// Package: shared register offsets and bit positions of the error capture bank.
// Assumes a 32-bit host data path and byte offsets of 12 bits.
package errcap_pkg;
    localparam int DATA_W      = 32;
    localparam int OFF_W       = 12;
    localparam logic [OFF_W-1:0] OFF_FLAG = 12'h304;
    localparam logic [OFF_W-1:0] OFF_CTL  = 12'h308;
    localparam logic [OFF_W-1:0] OFF_ID   = 12'h30C;
    // bit positions inside the control word
    localparam int CTL_FMT_LSB = 28;
    localparam int CTL_TXN_LSB = 24;
    localparam int CTL_MSG_LSB = 16;
    // bit positions inside the ID word
    localparam int ID_DST_LSB  = 16;
    localparam int ID_SRC_LSB  = 0;
endpackage

// File: rtl/errcap_field.sv
// Module: one capture field with a strobed writer and a host writer.
// Assumes: the strobe outranks the host write; both are ignored while locked.
module errcap_field #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         locked_i,
    input  logic         host_we_i,
    input  logic [W-1:0] host_val_i,
    input  logic         stb_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] q_o
);
    // Field storage: strobe first, then host write, frozen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (!locked_i) begin
            if (stb_i) begin
                q_o <= val_i;
            end else if (host_we_i) begin
                q_o <= host_val_i;
            end
        end
    end

    p_strobe_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_i && stb_i) |=> (q_o == $past(val_i)));
    p_locked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked_i |=> (q_o == $past(q_o)));
    p_host_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_i && !stb_i && host_we_i) |=> (q_o == $past(host_val_i)));
endmodule

// File: rtl/errcap_flag.sv
// Module: error-detected flag that also serves as the capture lock.
// Assumes: an error pulse outranks a host write of the flag in the same cycle.
module errcap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic err_det_i,
    input  logic host_we_i,
    input  logic host_bit_i,
    output logic flag_o
);
    // Flag register: set by detect, loaded by host otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (err_det_i) begin
            flag_o <= 1'b1;
        end else if (host_we_i) begin
            flag_o <= host_bit_i;
        end
    end

    p_detect_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_det_i |=> flag_o);
    p_host_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_det_i && host_we_i) |=> (flag_o == $past(host_bit_i)));
endmodule

// File: rtl/errcap_bank.sv
// Module: error capture register bank (top).
// Holds the ID capture word and the control capture word, the error flag,
// and a combinational host read mux. Assumes user logic pulses the field
// strobes together with err_det_i for the error being captured.
module errcap_bank
    import errcap_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int TYPE_W = 4,
    parameter int SUB_W  = 2,
    parameter int HI_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_det_i,
    input  logic              dst_wr_i,
    input  logic [ID_W-1:0]   dst_val_i,
    input  logic              src_wr_i,
    input  logic [ID_W-1:0]   src_val_i,
    input  logic              fmt_wr_i,
    input  logic [TYPE_W-1:0] fmt_val_i,
    input  logic              txn_wr_i,
    input  logic [TYPE_W-1:0] txn_val_i,
    input  logic              ltr_wr_i,
    input  logic [SUB_W-1:0]  ltr_val_i,
    input  logic              mbx_wr_i,
    input  logic [SUB_W-1:0]  mbx_val_i,
    input  logic              seg_wr_i,
    input  logic [HI_W-1:0]   seg_val_i,
    input  logic              xmbx_wr_i,
    input  logic [HI_W-1:0]   xmbx_val_i,
    input  logic              host_sel_i,
    input  logic              host_we_i,
    input  logic [OFF_W-1:0]  host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o
);
    localparam int MSG_W  = 2 * SUB_W + HI_W;
    localparam int LTR_LSB = CTL_MSG_LSB;
    localparam int MBX_LSB = CTL_MSG_LSB + SUB_W;
    localparam int HI_LSB  = CTL_MSG_LSB + 2 * SUB_W;

    logic locked;
    logic wr_flag, wr_ctl, wr_id;
    logic [ID_W-1:0]   dst_q, src_q;
    logic [TYPE_W-1:0] fmt_q, txn_q;
    logic [SUB_W-1:0]  ltr_q, mbx_q;
    logic [HI_W-1:0]   hi_q;
    logic              hi_stb;
    logic [HI_W-1:0]   hi_val;
    logic [MSG_W-1:0]  msg_q;

    // Host write decode per register.
    always_comb begin
        wr_flag = host_sel_i && host_we_i && (host_addr_i == OFF_FLAG);
        wr_ctl  = host_sel_i && host_we_i && (host_addr_i == OFF_CTL);
        wr_id   = host_sel_i && host_we_i && (host_addr_i == OFF_ID);
    end

    // Upper message-info nibble: segment writer outranks extended mailbox.
    always_comb begin
        hi_stb = seg_wr_i || xmbx_wr_i;
        hi_val = seg_wr_i ? seg_val_i : xmbx_val_i;
    end

    errcap_flag u_flag (
        .clk(clk), .rst_n(rst_n), .err_det_i(err_det_i),
        .host_we_i(wr_flag), .host_bit_i(host_wdata_i[0]), .flag_o(locked)
    );

    errcap_field #(.W(ID_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_id),
        .host_val_i(host_wdata_i[ID_DST_LSB +: ID_W]),
        .stb_i(dst_wr_i), .val_i(dst_val_i), .q_o(dst_q)
    );
    errcap_field #(.W(ID_W)) u_src (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_id),
        .host_val_i(host_wdata_i[ID_SRC_LSB +: ID_W]),
        .stb_i(src_wr_i), .val_i(src_val_i), .q_o(src_q)
    );
    errcap_field #(.W(TYPE_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_ctl),
        .host_val_i(host_wdata_i[CTL_FMT_LSB +: TYPE_W]),
        .stb_i(fmt_wr_i), .val_i(fmt_val_i), .q_o(fmt_q)
    );
    errcap_field #(.W(TYPE_W)) u_txn (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_ctl),
        .host_val_i(host_wdata_i[CTL_TXN_LSB +: TYPE_W]),
        .stb_i(txn_wr_i), .val_i(txn_val_i), .q_o(txn_q)
    );
    errcap_field #(.W(SUB_W)) u_ltr (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_ctl),
        .host_val_i(host_wdata_i[LTR_LSB +: SUB_W]),
        .stb_i(ltr_wr_i), .val_i(ltr_val_i), .q_o(ltr_q)
    );
    errcap_field #(.W(SUB_W)) u_mbx (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_ctl),
        .host_val_i(host_wdata_i[MBX_LSB +: SUB_W]),
        .stb_i(mbx_wr_i), .val_i(mbx_val_i), .q_o(mbx_q)
    );
    errcap_field #(.W(HI_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .locked_i(locked), .host_we_i(wr_ctl),
        .host_val_i(host_wdata_i[HI_LSB +: HI_W]),
        .stb_i(hi_stb), .val_i(hi_val), .q_o(hi_q)
    );

    // Message-info assembly: upper nibble, mailbox, letter.
    always_comb msg_q = {hi_q, mbx_q, ltr_q};

    // Host read mux; unmapped offsets and reserved bits read zero.
    always_comb begin
        host_rdata_o = '0;
        if (host_sel_i) begin
            if (host_addr_i == OFF_FLAG) begin
                host_rdata_o[0] = locked;
            end else if (host_addr_i == OFF_CTL) begin
                host_rdata_o[CTL_FMT_LSB +: TYPE_W] = fmt_q;
                host_rdata_o[CTL_TXN_LSB +: TYPE_W] = txn_q;
                host_rdata_o[CTL_MSG_LSB +: MSG_W]  = msg_q;
            end else if (host_addr_i == OFF_ID) begin
                host_rdata_o[ID_DST_LSB +: ID_W] = dst_q;
                host_rdata_o[ID_SRC_LSB +: ID_W] = src_q;
            end
        end
    end

    p_seg_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && seg_wr_i) |=> (hi_q == $past(seg_val_i)));
    p_xmbx_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && xmbx_wr_i && !seg_wr_i) |=> (hi_q == $past(xmbx_val_i)));
    p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (msg_q == $past(msg_q) && dst_q == $past(dst_q)));
    p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel_i |-> (host_rdata_o == '0));
endmodule

// File: tb/errcap_bank_bench.sv
// Directed bench for errcap_bank: one task per scenario, each self-checking.
module errcap_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic err_det;
    logic dst_wr, src_wr, fmt_wr, txn_wr, ltr_wr, mbx_wr, seg_wr, xmbx_wr;
    logic [15:0] dst_val, src_val;
    logic [3:0]  fmt_val, txn_val, seg_val, xmbx_val;
    logic [1:0]  ltr_val, mbx_val;
    logic        h_sel, h_we;
    logic [11:0] h_addr;
    logic [31:0] h_wdata, h_rdata;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errcap_bank u_errcap_bank (
        .clk(clk), .rst_n(rst_n), .err_det_i(err_det),
        .dst_wr_i(dst_wr), .dst_val_i(dst_val), .src_wr_i(src_wr), .src_val_i(src_val),
        .fmt_wr_i(fmt_wr), .fmt_val_i(fmt_val), .txn_wr_i(txn_wr), .txn_val_i(txn_val),
        .ltr_wr_i(ltr_wr), .ltr_val_i(ltr_val), .mbx_wr_i(mbx_wr), .mbx_val_i(mbx_val),
        .seg_wr_i(seg_wr), .seg_val_i(seg_val), .xmbx_wr_i(xmbx_wr), .xmbx_val_i(xmbx_val),
        .host_sel_i(h_sel), .host_we_i(h_we), .host_addr_i(h_addr),
        .host_wdata_i(h_wdata), .host_rdata_o(h_rdata)
    );

    task automatic idle_all();
        err_det = 0; dst_wr = 0; src_wr = 0; fmt_wr = 0; txn_wr = 0;
        ltr_wr = 0; mbx_wr = 0; seg_wr = 0; xmbx_wr = 0;
        dst_val = 0; src_val = 0; fmt_val = 0; txn_val = 0;
        ltr_val = 0; mbx_val = 0; seg_val = 0; xmbx_val = 0;
        h_sel = 0; h_we = 0; h_addr = 0; h_wdata = 0;
    endtask

    // One rising edge, then return at the falling edge with inputs idle.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_all();
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
        h_sel = 1; h_we = 0; h_addr = a;
        #1;
        check(req, h_rdata, exp);
        h_sel = 0; h_addr = 0;
        #1;
    endtask

    // Host write set up on the falling edge; caller may add strobes before tick.
    task automatic host_wr_setup(logic [11:0] a, logic [31:0] d);
        h_sel = 1; h_we = 1; h_addr = a; h_wdata = d;
    endtask

    task automatic t_reset();
        rd_check("R1 flag", 12'h304, 32'h0);
        rd_check("R1 ctl", 12'h308, 32'h0);
        rd_check("R1 id", 12'h30C, 32'h0);
    endtask

    task automatic t_ids();
        dst_wr = 1; dst_val = 16'hA5C3; src_wr = 1; src_val = 16'h1234;
        tick();
        rd_check("R2 both ids", 12'h30C, 32'hA5C3_1234);
        src_wr = 1; src_val = 16'h0F0F;
        tick();
        rd_check("R2 src only", 12'h30C, 32'hA5C3_0F0F);
    endtask

    task automatic t_types();
        fmt_wr = 1; fmt_val = 4'h9; txn_wr = 1; txn_val = 4'h6;
        tick();
        rd_check("R3 fmt txn", 12'h308, 32'h9600_0000);
    endtask

    task automatic t_msg_lo();
        ltr_wr = 1; ltr_val = 2'b10; mbx_wr = 1; mbx_val = 2'b01;
        tick();
        rd_check("R4 letter+mailbox", 12'h308, 32'h9606_0000);
    endtask

    task automatic t_msg_hi();
        seg_wr = 1; seg_val = 4'hB; xmbx_wr = 1; xmbx_val = 4'h3;
        tick();
        rd_check("R5 segment wins", 12'h308, 32'h96B6_0000);
        xmbx_wr = 1; xmbx_val = 4'h3;
        tick();
        rd_check("R6 xmbx alone", 12'h308, 32'h9636_0000);
        seg_wr = 1; seg_val = 4'h5;
        tick();
        rd_check("R5 segment alone", 12'h308, 32'h9656_0000);
    endtask

    task automatic t_host_unlocked();
        host_wr_setup(12'h308, 32'hFFFF_FFFF);
        fmt_wr = 1; fmt_val = 4'h2;
        tick();
        rd_check("R9 ctl overwrite, strobe wins", 12'h308, 32'h2FFF_0000);
        host_wr_setup(12'h30C, 32'h0000_0000);
        src_wr = 1; src_val = 16'hBEEF;
        tick();
        rd_check("R9 id overwrite, strobe wins", 12'h30C, 32'h0000_BEEF);
        host_wr_setup(12'h304, 32'hFFFF_FFFE);
        tick();
        rd_check("R9 flag reserved bits", 12'h304, 32'h0);
    endtask

    task automatic t_lock();
        err_det = 1; dst_wr = 1; dst_val = 16'h1111; fmt_wr = 1; fmt_val = 4'h7;
        tick();
        rd_check("R7 flag set", 12'h304, 32'h1);
        rd_check("R7 capture id", 12'h30C, 32'h1111_BEEF);
        rd_check("R7 capture ctl", 12'h308, 32'h7FFF_0000);
        dst_wr = 1; dst_val = 16'h2222; seg_wr = 1; seg_val = 4'h1;
        fmt_wr = 1; fmt_val = 4'h3; ltr_wr = 1; ltr_val = 2'b00; err_det = 1;
        tick();
        rd_check("R7 id frozen", 12'h30C, 32'h1111_BEEF);
        rd_check("R7 ctl frozen", 12'h308, 32'h7FFF_0000);
        host_wr_setup(12'h308, 32'h0);
        tick();
        rd_check("R10 ctl host ignored", 12'h308, 32'h7FFF_0000);
        host_wr_setup(12'h30C, 32'h0);
        tick();
        rd_check("R10 id host ignored", 12'h30C, 32'h1111_BEEF);
    endtask

    task automatic t_clear();
        host_wr_setup(12'h304, 32'h0);
        tick();
        rd_check("R8 flag cleared", 12'h304, 32'h0);
        dst_wr = 1; dst_val = 16'h3333;
        tick();
        rd_check("R8 unlocked capture", 12'h30C, 32'h3333_BEEF);
        err_det = 1;
        tick();
        host_wr_setup(12'h304, 32'h0);
        err_det = 1;
        tick();
        rd_check("R8 detect beats clear", 12'h304, 32'h1);
        host_wr_setup(12'h304, 32'h0);
        tick();
        rd_check("R8 clear again", 12'h304, 32'h0);
    endtask

    task automatic t_unmapped();
        rd_check("R11 offset 0x300", 12'h300, 32'h0);
        rd_check("R11 offset 0x310", 12'h310, 32'h0);
        rd_check("R11 offset 0x30A", 12'h30A, 32'h0);
    endtask

    initial begin
        idle_all();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ids();
        t_types();
        t_msg_lo();
        t_msg_hi();
        t_host_unlocked();
        t_lock();
        t_clear();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: got=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule